// File: doc/BRIEF.md
# PCIe Configuration Window Translator

This block sits between a host bus and a PCIe controller core. It turns host accesses that land in a 64 KB configuration window into the address form the core expects for configuration cycles. Software programs the base of the window and a pair of 16-bit bus/device/function (BDF) targets. After that, each load or store into the window becomes one configuration request to the core, tagged as Type 0 or Type 1.

The target BDF does not come from the host address. Host address bit 12 picks one of the two stored BDF values. The 4 KB slot of the window that the access hits decides the cycle type: slot zero gives Type 0 and every other slot gives Type 1.

Accesses that miss the window, or that land in its upper 32 KB, raise an error flag instead of a request. All results appear one clock after the access is presented.

The host presents a word address (bits 31:2) and byte enables. The core receives a full 32-bit address with the following layout:
- bits 31:16: the selected BDF value (bus number in the upper byte, device/function in the lower byte).
- bits 15:12: zero.
- bits 11:2: the host's register offset.
- bits 1:0: zero.

Top module: `cfg_window_xlat`

## Requirements
- R1: While reset is held and right after it, coreReq, hostErr, coreType1, coreAddr and coreByteEn are zero, and both register locations read back as zero.
- R2: Register location regSel=0 holds the window base. A write keeps regWrData[31:16]; read-back shows those bits with bits [15:0] as zero. The new value is visible on regRdData in the cycle after the write.
- R3: Register location regSel=1 holds the BDF pair: bits [15:0] are BDF0 and bits [31:16] are BDF1. A write is read back unchanged in the next cycle.
- R4: A request hits when hostValid is high, hostAddr[31:16] equals the stored base, and hostAddr[15] is 0. On a hit, coreReq is high for exactly one cycle, the cycle after the access.
- R5: When hostValid is high but hostAddr[31:16] differs from the base, or hostAddr[15] is 1, hostErr is high in the next cycle and coreReq stays low.
- R6: coreType1 is 0 when hostAddr[15:12] is all zero and 1 for any other value. It is valid together with coreReq.
- R7: coreAddr[31:16] carries BDF0 when hostAddr[12] is 0 and BDF1 when hostAddr[12] is 1.
- R8: coreAddr[15:12] and coreAddr[1:0] are zero, and coreAddr[11:2] equals hostAddr[11:2].
- R9: coreByteEn equals the hostByteEn of the access that produced the request.
- R10: In a cycle that follows one with hostValid low, coreReq and hostErr are low, and coreAddr, coreByteEn and coreType1 are zero.
- R11: An access presented in the same cycle as a register write is translated with the values held before that write. An access in the following cycle uses the new values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regSel | input | 1 | Register location: 0 window base, 1 BDF pair |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Read-back of the selected location |
| hostValid | input | 1 | Host access present |
| hostAddr | input | 30 | Host word address, bits 31:2 |
| hostByteEn | input | 4 | Host byte enables |
| coreReq | output | 1 | Configuration request strobe to the core |
| coreAddr | output | 32 | Translated configuration address |
| coreByteEn | output | 4 | Byte enables forwarded with the request |
| coreType1 | output | 1 | 1 for a Type 1 cycle, 0 for Type 0 |
| hostErr | output | 1 | Access missed the usable window |

## Verification
The translation is tried in four slots:
- slot 0, which checks Type 0 with BDF0;
- slot 1, which checks Type 1 with BDF1;
- slot 2, where bit 12 is clear but the type is still Type 1, so the BDF choice and the type choice are shown to be independent;
- slot 7, which checks Type 1 with BDF1 at a high register offset.

Each access uses different byte-enable patterns and register offsets, so bit slips in the register field or the enables show up.

Error cases cover both failure modes: an access to the upper half of the window and an access to an address just above it. After the base is moved, an access to the old window checks that the base is really compared.

A register write issued in the same cycle as an access, followed by an access in the next cycle, separates old-value from new-value behaviour.

// File: rtl/ctw_pkg.sv
package ctw_pkg;
  typedef struct packed {
    logic req;    // translate and issue
    logic err;    // access outside usable window
    logic type1;  // Type 1 configuration cycle
    logic selHi;  // use upper BDF of the pair
  } ctwStrobe_t;
endpackage

// File: rtl/ctw_control.sv
module ctw_control
  import ctw_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int WIN_W  = 16,
  parameter int SLOT_W = 12
) (
  input  logic                    hostValid,
  input  logic [ADDR_W-1:SLOT_W]  hostHiAddr,
  input  logic [ADDR_W-1:WIN_W]   baseHi,
  output ctwStrobe_t              st
);
  logic inWindow;
  logic lowHalf;

  always_comb begin
    inWindow = (hostHiAddr[ADDR_W-1:WIN_W] == baseHi);
    lowHalf  = ~hostHiAddr[WIN_W-1];
    st.req   = hostValid & inWindow & lowHalf;
    st.err   = hostValid & ~(inWindow & lowHalf);
    st.type1 = |hostHiAddr[WIN_W-1:SLOT_W];
    st.selHi = hostHiAddr[SLOT_W];
  end
endmodule

// File: rtl/ctw_datapath.sv
module ctw_datapath
  import ctw_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int WIN_W  = 16,
  parameter int SLOT_W = 12,
  parameter int BDF_W  = 16,
  parameter int BE_W   = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   regWrEn,
  input  logic                   regSel,
  input  logic [ADDR_W-1:0]      regWrData,
  output logic [ADDR_W-1:0]      regRdData,
  output logic [ADDR_W-1:WIN_W]  baseHi,
  input  ctwStrobe_t             st,
  input  logic [SLOT_W-1:2]      regOffset,
  input  logic [BE_W-1:0]        hostByteEn,
  output logic                   coreReq,
  output logic [ADDR_W-1:0]      coreAddr,
  output logic [BE_W-1:0]        coreByteEn,
  output logic                   coreType1,
  output logic                   hostErr
);
  localparam int NUM_BDF = 2;
  localparam int GAP_W   = WIN_W - SLOT_W;

  logic [BDF_W-1:0] bdfReg [NUM_BDF];
  logic [BDF_W-1:0] bdfSel;

  always_ff @(posedge clk) begin
    if (!rstN) baseHi <= '0;
    else if (regWrEn && !regSel) baseHi <= regWrData[ADDR_W-1:WIN_W];
  end

  for (genvar i = 0; i < NUM_BDF; i++) begin : gBdf
    always_ff @(posedge clk) begin
      if (!rstN) bdfReg[i] <= '0;
      else if (regWrEn && regSel) bdfReg[i] <= regWrData[i*BDF_W +: BDF_W];
    end
  end

  always_comb begin
    regRdData = regSel ? {bdfReg[1], bdfReg[0]} : {baseHi, {WIN_W{1'b0}}};
    bdfSel    = st.selHi ? bdfReg[1] : bdfReg[0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      coreReq    <= 1'b0;
      hostErr    <= 1'b0;
      coreAddr   <= '0;
      coreByteEn <= '0;
      coreType1  <= 1'b0;
    end else begin
      coreReq <= st.req;
      hostErr <= st.err;
      if (st.req) begin
        coreAddr   <= {bdfSel, {GAP_W{1'b0}}, regOffset, 2'b00};
        coreByteEn <= hostByteEn;
        coreType1  <= st.type1;
      end else begin
        coreAddr   <= '0;
        coreByteEn <= '0;
        coreType1  <= 1'b0;
      end
    end
  end

  assert_base_low_R2: assert property (@(posedge clk) disable iff (!rstN)
    !regSel |-> regRdData[WIN_W-1:0] == '0);
  assert_base_wr_R2: assert property (@(posedge clk) disable iff (!rstN)
    ($past(regWrEn && !regSel) && !regSel) |->
      regRdData[ADDR_W-1:WIN_W] == $past(regWrData[ADDR_W-1:WIN_W]));
  assert_bdf_wr_R3: assert property (@(posedge clk) disable iff (!rstN)
    ($past(regWrEn && regSel) && regSel) |-> regRdData == $past(regWrData));
endmodule

// File: rtl/cfg_window_xlat.sv
module cfg_window_xlat
  import ctw_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int WIN_W  = 16,
  parameter int SLOT_W = 12,
  parameter int BE_W   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regSel,
  input  logic [ADDR_W-1:0] regWrData,
  output logic [ADDR_W-1:0] regRdData,
  input  logic              hostValid,
  input  logic [ADDR_W-1:2] hostAddr,
  input  logic [BE_W-1:0]   hostByteEn,
  output logic              coreReq,
  output logic [ADDR_W-1:0] coreAddr,
  output logic [BE_W-1:0]   coreByteEn,
  output logic              coreType1,
  output logic              hostErr
);
  localparam int BDF_W = ADDR_W - WIN_W;

  ctwStrobe_t                  st;
  logic [ADDR_W-1:WIN_W]       baseHi;

  ctw_control #(.ADDR_W(ADDR_W), .WIN_W(WIN_W), .SLOT_W(SLOT_W)) uCtl (
    .hostValid (hostValid),
    .hostHiAddr(hostAddr[ADDR_W-1:SLOT_W]),
    .baseHi    (baseHi),
    .st        (st)
  );

  ctw_datapath #(.ADDR_W(ADDR_W), .WIN_W(WIN_W), .SLOT_W(SLOT_W),
                 .BDF_W(BDF_W), .BE_W(BE_W)) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .regWrEn   (regWrEn),
    .regSel    (regSel),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .baseHi    (baseHi),
    .st        (st),
    .regOffset (hostAddr[SLOT_W-1:2]),
    .hostByteEn(hostByteEn),
    .coreReq   (coreReq),
    .coreAddr  (coreAddr),
    .coreByteEn(coreByteEn),
    .coreType1 (coreType1),
    .hostErr   (hostErr)
  );

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    !$past(hostValid) |-> (!coreReq && !hostErr));
  assert_upper_half_R5: assert property (@(posedge clk) disable iff (!rstN)
    $past(hostValid && hostAddr[WIN_W-1]) |-> (hostErr && !coreReq));
  assert_type_R6: assert property (@(posedge clk) disable iff (!rstN)
    coreReq |-> coreType1 == ($past(hostAddr[WIN_W-1:SLOT_W]) != '0));
  assert_fields_R8: assert property (@(posedge clk) disable iff (!rstN)
    coreReq |-> (coreAddr[WIN_W-1:SLOT_W] == '0 && coreAddr[1:0] == 2'b00 &&
                 coreAddr[SLOT_W-1:2] == $past(hostAddr[SLOT_W-1:2])));
  assert_byte_en_R9: assert property (@(posedge clk) disable iff (!rstN)
    coreReq |-> coreByteEn == $past(hostByteEn));
endmodule

// File: tb/tb_cfg_window_xlat.sv
module tb_cfg_window_xlat;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0;
  logic        rstN = 0;
  logic        regWrEn = 0;
  logic        regSel = 0;
  logic [31:0] regWrData = 0;
  logic [31:0] regRdData;
  logic        hostValid = 0;
  logic [31:2] hostAddr = 0;
  logic [3:0]  hostByteEn = 0;
  logic        coreReq;
  logic [31:0] coreAddr;
  logic [3:0]  coreByteEn;
  logic        coreType1;
  logic        hostErr;

  int tests = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_window_xlat dut (.*);

  typedef struct {
    logic        req;
    logic        err;
    logic [31:0] addr;
    logic [3:0]  be;
    logic        type1;
    bit          sameCycleWr;
  } expItem_t;

  expItem_t expQ[$];
  logic [31:0] mBase = 0;
  logic [31:0] mBdf  = 0;
  bit monitorOn = 0;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one driven cycle: expectation computed from model values before any write
  task automatic drive(bit v, logic [31:0] a, logic [3:0] be,
                       bit wr, bit sel, logic [31:0] wd);
    expItem_t e;
    bit hit;
    logic [15:0] b;
    @(negedge clk);
    hostValid = v; hostAddr = a[31:2]; hostByteEn = be;
    regWrEn = wr; regSel = sel; regWrData = wd;
    hit = v && (a[31:16] == mBase[31:16]) && !a[15];
    b = a[12] ? mBdf[31:16] : mBdf[15:0];
    e.req = hit;
    e.err = v && !hit;
    e.addr = hit ? {b, 4'h0, a[11:2], 2'b00} : 32'h0;
    e.be = hit ? be : 4'h0;
    e.type1 = hit ? (a[15:12] != 4'h0) : 1'b0;
    e.sameCycleWr = wr && v;
    expQ.push_back(e);
    if (wr && !sel) mBase = {wd[31:16], 16'h0};
    if (wr && sel) mBdf = wd;
  endtask

  task automatic access(logic [31:0] a, logic [3:0] be);
    drive(1, a, be, 0, 0, 0);
  endtask

  task automatic writeReg(bit sel, logic [31:0] wd);
    drive(0, 0, 0, 1, sel, wd);
  endtask

  task automatic readReg(bit sel, string tag);
    drive(0, 0, 0, 0, sel, 0);
    #1 check(tag, regRdData, sel ? mBdf : mBase);
  endtask

  // scoreboard monitor
  always @(posedge clk) begin
    #1;
    if (monitorOn && expQ.size() > 0) begin
      expItem_t e;
      string pre;
      e = expQ.pop_front();
      pre = e.sameCycleWr ? "R11 " : "";
      if (!e.req && !e.err) begin
        check("R10 idle req/err", {30'h0, coreReq, hostErr}, 32'h0);
        check("R10 idle fields", coreAddr | {27'h0, coreType1, coreByteEn}, 32'h0);
      end else begin
        check({pre, "R4 coreReq"}, {31'h0, coreReq}, {31'h0, e.req});
        check({pre, "R5 hostErr"}, {31'h0, hostErr}, {31'h0, e.err});
        if (e.req) begin
          check({pre, "R6 type"}, {31'h0, coreType1}, {31'h0, e.type1});
          check({pre, "R7 bdf"}, {16'h0, coreAddr[31:16]}, {16'h0, e.addr[31:16]});
          check({pre, "R8 low addr"}, {16'h0, coreAddr[15:0]}, {16'h0, e.addr[15:0]});
          check({pre, "R9 byteEn"}, {28'h0, coreByteEn}, {28'h0, e.be});
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    fails++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    check("R1 outputs", {27'h0, coreReq, hostErr, coreType1, 2'b0} | coreAddr, 32'h0);
    check("R1 byteEn", {28'h0, coreByteEn}, 32'h0);
    regSel = 0; #1 check("R1 base", regRdData, 32'h0);
    regSel = 1; #1 check("R1 bdf", regRdData, 32'h0);
    rstN = 1;
    monitorOn = 1;

    writeReg(0, 32'h3A5B_1234);
    readReg(0, "R2 base readback");
    check("R2 base low zero", regRdData, 32'h3A5B_0000);
    writeReg(1, 32'h0208_0100);
    readReg(1, "R3 bdf readback");

    access(32'h3A5B_0040, 4'b1111);  // slot0 Type0 BDF0
    access(32'h3A5B_1FFC, 4'b0011);  // slot1 Type1 BDF1
    access(32'h3A5B_2104, 4'b1000);  // slot2 Type1 BDF0
    access(32'h3A5B_7E08, 4'b0100);  // slot7 Type1 BDF1
    access(32'h3A5B_8000, 4'b1111);  // R5 upper half
    access(32'h3A5C_0000, 4'b1111);  // R5 miss
    drive(0, 0, 0, 0, 0, 0);         // R10 idle
    drive(0, 0, 0, 0, 0, 0);

    // R11: write concurrent with access uses old BDF, next uses new
    drive(1, 32'h3A5B_0010, 4'b0001, 1, 1, 32'hFFEE_1122);
    access(32'h3A5B_1000, 4'b0010);

    writeReg(0, 32'h0000_0000);
    access(32'h0000_3008, 4'b1100);
    access(32'h3A5B_0000, 4'b1111);  // old window now misses
    drive(0, 0, 0, 0, 0, 0);

    repeat (3) @(negedge clk);
    check("R4 queue drained", expQ.size(), 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule